// File: doc/BRIEF.md
# ROM Patch Redirect Unit

This unit sits next to the instruction fetch path of an 8-bit processor. It allows up to two faulty instructions in mask ROM to be replaced by code held in RAM. Software loads two 16-bit patch addresses and an enable byte over a byte-wide register bus. The unit then watches every fetch address along with a strobe that marks opcode fetches. When an opcode fetch hits an enabled patch address, the unit raises a redirect request in that same cycle. The request carries the start of that slot's RAM window, and the core loads this address into its program counter.

Each slot owns a fixed 32-byte RAM window. The first window sits directly below the second, so patch code that runs past the end of slot 1 continues into slot 2 without a jump. Fetches from inside either window are never compared. This prevents patch code from redirecting back into itself. The jump back to ROM at the end of a patch, the RAM itself and the processor core are all outside this unit.

Top module: `patch_redirect`

## Requirements
- R1: After reset, both patch addresses read 0x0000 and the enable byte reads 0x00. No redirect is issued for any fetch until software enables a slot.
- R2: Patch address 1 is written and read as a high byte at 0x0217 and a low byte at 0x0218. Patch address 2 uses 0x0219 (high) and 0x021A (low). Reads are combinational on `cfg_addr`. A write takes effect on the next clock edge.
- R3: The enable byte is at 0x021B. Bit 0 enables slot 1 and bit 1 enables slot 2, where 1 means enabled. Bits 3:2 are stored and read back, but they enable nothing. Bits 7:4 ignore writes and always read 0.
- R4: A read from any other address returns 0x00. A write to any other address changes no register.
- R5: When slot 1 is enabled and an opcode fetch (`op_fetch`=1) presents an address equal to patch address 1, `redir_req` is 1 in that same cycle and `redir_pc` is 0x02C0.
- R6: When slot 2 is enabled and an opcode fetch matches patch address 2, `redir_req` is 1 in that same cycle and `redir_pc` is 0x02E0.
- R7: No redirect is issued while `op_fetch` is 0, even if the address matches. When `redir_req` is 0, `redir_pc` is 0x0000.
- R8: A slot whose enable bit is 0 never redirects. This holds on the cycle after its bit is cleared.
- R9: If both enabled slots match in the same cycle, slot 1 wins and `redir_pc` is 0x02C0.
- R10: A fetch address in 0x02C0–0x02FF never causes a redirect. Addresses just outside this range (0x02BF, 0x0300) compare normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr | input | 16 | Register bus address |
| cfg_wdata | input | 8 | Register bus write data |
| cfg_we | input | 1 | Register bus write strobe |
| cfg_rdata | output | 8 | Register bus read data (combinational) |
| fetch_pc | input | 16 | Current fetch address |
| op_fetch | input | 1 | High when the fetch is an instruction's opcode byte |
| redir_req | output | 1 | Redirect request, same cycle as the fetch |
| redir_pc | output | 16 | Redirect target address |

## Verification
The assertions assume that `op_fetch` and `fetch_pc` are settled well before each sampling edge. They also assume that register writes are single-cycle strobes whose effect is visible only from the next cycle on. The bench drives every input on the falling edge and keeps each write to one cycle, so both assumptions hold. One scenario deliberately breaks the rule against loading the same address into both slots, so that slot priority can be shown. The assertions are written to stay valid in that case.

// File: rtl/patch_redirect.sv
module patch_redirect #(
  parameter logic [15:0] REG_BASE  = 16'h0217,
  parameter logic [15:0] WIN_BASE  = 16'h02C0,
  parameter int          WIN_BYTES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cfg_addr,
  input  logic [7:0]  cfg_wdata,
  input  logic        cfg_we,
  output logic [7:0]  cfg_rdata,
  input  logic [15:0] fetch_pc,
  input  logic        op_fetch,
  output logic        redir_req,
  output logic [15:0] redir_pc
);
  localparam logic [15:0] A1_HI   = REG_BASE;
  localparam logic [15:0] A1_LO   = REG_BASE + 16'd1;
  localparam logic [15:0] A2_HI   = REG_BASE + 16'd2;
  localparam logic [15:0] A2_LO   = REG_BASE + 16'd3;
  localparam logic [15:0] EN_REG  = REG_BASE + 16'd4;
  localparam logic [15:0] TGT1    = WIN_BASE;
  localparam logic [15:0] TGT2    = WIN_BASE + 16'(WIN_BYTES);
  localparam logic [15:0] WIN_END = WIN_BASE + 16'(2 * WIN_BYTES - 1);

  logic [15:0] pa1, pa2;
  logic [3:0]  en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa1 <= '0;
      pa2 <= '0;
      en  <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        A1_HI:   pa1[15:8] <= cfg_wdata;
        A1_LO:   pa1[7:0]  <= cfg_wdata;
        A2_HI:   pa2[15:8] <= cfg_wdata;
        A2_LO:   pa2[7:0]  <= cfg_wdata;
        EN_REG:  en        <= cfg_wdata[3:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfg_addr)
      A1_HI:   cfg_rdata = pa1[15:8];
      A1_LO:   cfg_rdata = pa1[7:0];
      A2_HI:   cfg_rdata = pa2[15:8];
      A2_LO:   cfg_rdata = pa2[7:0];
      EN_REG:  cfg_rdata = {4'b0000, en};
      default: cfg_rdata = 8'h00;
    endcase
  end

  wire in_win = (fetch_pc >= WIN_BASE) && (fetch_pc <= WIN_END);
  wire armed  = op_fetch && !in_win;
  wire hit1   = armed && en[0] && (fetch_pc == pa1);
  wire hit2   = armed && en[1] && (fetch_pc == pa2);

  assign redir_req = hit1 || hit2;
  assign redir_pc  = hit1 ? TGT1 : (hit2 ? TGT2 : 16'h0000);
endmodule

// File: rtl/patch_redirect_chk.sv
module patch_redirect_chk #(
  parameter logic [15:0] REG_BASE  = 16'h0217,
  parameter logic [15:0] WIN_BASE  = 16'h02C0,
  parameter int          WIN_BYTES = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cfg_addr,
  input logic [7:0]  cfg_wdata,
  input logic        cfg_we,
  input logic [7:0]  cfg_rdata,
  input logic [15:0] fetch_pc,
  input logic        op_fetch,
  input logic        redir_req,
  input logic [15:0] redir_pc
);
  localparam logic [15:0] EN_REG  = REG_BASE + 16'd4;
  localparam logic [15:0] TGT1    = WIN_BASE;
  localparam logic [15:0] TGT2    = WIN_BASE + 16'(WIN_BYTES);
  localparam logic [15:0] WIN_END = WIN_BASE + 16'(2 * WIN_BYTES - 1);

  wire mapped = (cfg_addr >= REG_BASE) && (cfg_addr <= EN_REG);

  a_r7_needs_opfetch: assert property (@(posedge clk) disable iff (!rst_n)
    redir_req |-> op_fetch);

  a_r7_idle_target: assert property (@(posedge clk) disable iff (!rst_n)
    !redir_req |-> (redir_pc == 16'h0000));

  a_r5_target_legal: assert property (@(posedge clk) disable iff (!rst_n)
    redir_req |-> (redir_pc == TGT1 || redir_pc == TGT2));

  a_r10_no_window_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_pc >= WIN_BASE && fetch_pc <= WIN_END) |-> !redir_req);

  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == EN_REG) |-> (cfg_rdata[7:4] == 4'h0));

  a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (cfg_rdata == 8'h00));

  a_r8_disable_all: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == EN_REG && cfg_wdata[1:0] == 2'b00) |=> !redir_req);
endmodule

bind patch_redirect patch_redirect_chk #(
  .REG_BASE(REG_BASE), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .cfg_we(cfg_we), .cfg_rdata(cfg_rdata), .fetch_pc(fetch_pc),
  .op_fetch(op_fetch), .redir_req(redir_req), .redir_pc(redir_pc)
);

// File: tb/patch_redirect_tb.sv
module patch_redirect_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_rdata;
  logic [15:0] fetch_pc = '0;
  logic        op_fetch = 1'b0;
  logic        redir_req;
  logic [15:0] redir_pc;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  patch_redirect u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_we(cfg_we), .cfg_rdata(cfg_rdata), .fetch_pc(fetch_pc),
    .op_fetch(op_fetch), .redir_req(redir_req), .redir_pc(redir_pc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input logic [7:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1 chk(req, {24'h0, cfg_rdata}, {24'h0, exp});
  endtask

  task automatic fetch_chk(input string req, input logic [15:0] pc, input logic op,
                           input logic exp_req, input logic [15:0] exp_pc);
    @(negedge clk);
    fetch_pc = pc; op_fetch = op;
    #1;
    chk(req, {31'h0, redir_req}, {31'h0, exp_req});
    chk(req, {16'h0, redir_pc}, {16'h0, exp_pc});
    @(negedge clk);
    op_fetch = 1'b0;
  endtask

  task automatic set_slots(input logic [15:0] a1, input logic [15:0] a2, input logic [7:0] e);
    wr(16'h0217, a1[15:8]); wr(16'h0218, a1[7:0]);
    wr(16'h0219, a2[15:8]); wr(16'h021A, a2[7:0]);
    wr(16'h021B, e);
  endtask

  task automatic t_reset;
    rd_chk("R1", 16'h0217, 8'h00); rd_chk("R1", 16'h0218, 8'h00);
    rd_chk("R1", 16'h0219, 8'h00); rd_chk("R1", 16'h021A, 8'h00);
    rd_chk("R1", 16'h021B, 8'h00);
    fetch_chk("R1", 16'h0000, 1'b1, 1'b0, 16'h0000);
  endtask

  task automatic t_regs;
    set_slots(16'h1234, 16'hABCD, 8'h00);
    rd_chk("R2", 16'h0217, 8'h12); rd_chk("R2", 16'h0218, 8'h34);
    rd_chk("R2", 16'h0219, 8'hAB); rd_chk("R2", 16'h021A, 8'hCD);
    wr(16'h021B, 8'hFF);
    rd_chk("R3", 16'h021B, 8'h0F);
    wr(16'h021B, 8'h0C);
    fetch_chk("R3", 16'h1234, 1'b1, 1'b0, 16'h0000);
    wr(16'h021C, 8'h55); wr(16'h0216, 8'h66);
    rd_chk("R4", 16'h021C, 8'h00); rd_chk("R4", 16'h0216, 8'h00);
    rd_chk("R4", 16'h0217, 8'h12); rd_chk("R4", 16'h021B, 8'h0C);
  endtask

  task automatic t_slot1;
    set_slots(16'h1234, 16'h5678, 8'h01);
    fetch_chk("R5", 16'h1234, 1'b1, 1'b1, 16'h02C0);
    fetch_chk("R5", 16'h1235, 1'b1, 1'b0, 16'h0000);
    fetch_chk("R7", 16'h1234, 1'b0, 1'b0, 16'h0000);
    fetch_chk("R8", 16'h5678, 1'b1, 1'b0, 16'h0000);
  endtask

  task automatic t_slot2;
    set_slots(16'h1234, 16'h5678, 8'h02);
    fetch_chk("R6", 16'h5678, 1'b1, 1'b1, 16'h02E0);
    fetch_chk("R8", 16'h1234, 1'b1, 1'b0, 16'h0000);
    wr(16'h021B, 8'h03);
    fetch_chk("R6", 16'h5678, 1'b1, 1'b1, 16'h02E0);
    fetch_chk("R5", 16'h1234, 1'b1, 1'b1, 16'h02C0);
    wr(16'h021B, 8'h00);
    fetch_chk("R8", 16'h1234, 1'b1, 1'b0, 16'h0000);
    fetch_chk("R8", 16'h5678, 1'b1, 1'b0, 16'h0000);
  endtask

  task automatic t_priority;
    set_slots(16'h4000, 16'h4000, 8'h03);
    fetch_chk("R9", 16'h4000, 1'b1, 1'b1, 16'h02C0);
    wr(16'h021B, 8'h02);
    fetch_chk("R9", 16'h4000, 1'b1, 1'b1, 16'h02E0);
  endtask

  task automatic t_window;
    set_slots(16'h02C5, 16'h02FF, 8'h03);
    fetch_chk("R10", 16'h02C5, 1'b1, 1'b0, 16'h0000);
    fetch_chk("R10", 16'h02FF, 1'b1, 1'b0, 16'h0000);
    set_slots(16'h02BF, 16'h0300, 8'h03);
    fetch_chk("R10", 16'h02BF, 1'b1, 1'b1, 16'h02C0);
    fetch_chk("R10", 16'h0300, 1'b1, 1'b1, 16'h02E0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_regs;
    t_slot1;
    t_slot2;
    t_priority;
    t_window;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule